// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter

This block encodes a stream of audio samples into a consumer or professional two-channel digital audio line. Samples arrive over a ready/valid port and are taken strictly in order: the first one goes to subframe A, the next to subframe B, and so on alternately. Each subframe carries the following fields:

- a four-slot sync preamble
- auxiliary bits, sent as zero
- the audio word
- a validity flag
- a user-data bit
- a channel-status bit
- an even-parity bit

The serial output is biphase-mark coded, so it runs at two half-cells per bit.

A block of 384 subframes (192 A/B pairs) is counted internally. The channel-status bit and the user-data bit of each subframe come from two 384-entry one-bit banks, addressed by the subframe's position in the block. Both banks share a single write port. The validity flag is programmable separately for A and for B. When no sample is waiting at the start of a subframe, the block still sends that subframe, but with zero audio and the validity flag set. Half-cell length is a clock-divider parameter.

Top module: `bmc_audio_tx`

## Requirements
- R1: A subframe is 32 slots of two half-cells each, emitted back to back with no gap. Subframes alternate A (even position) and B (odd position), and the position counts 0..383 and then wraps to 0.
- R2: Slots 0-3 carry an 8-half-cell preamble, first half-cell first. Taken relative to a preceding line level of 0, the patterns are 11101000 at position 0, 11100010 at other even positions, and 11100100 at odd positions. When the line was 1 before the subframe, the pattern is inverted.
- R3: In slots 4..31 the line toggles at the start of every slot, and toggles again mid-slot exactly when the slot's bit is 1.
- R4: The audio word (AUDIO_W bits, default 20) is sent LSB first in slots 28-AUDIO_W..27, which by default is slots 8..27. Slots 4..27-AUDIO_W carry 0.
- R5: Slot 30 carries entry p of the channel-status bank and slot 29 carries entry p of the user bank, where p is the subframe position. A write with bank select 0 goes to the channel-status bank, and a write with bank select 1 goes to the user bank.
- R6: Slot 28 (validity) carries `inval_a` for A subframes and `inval_b` for B subframes, sampled when the subframe starts.
- R7: Slot 31 makes slots 4..31 carry an even number of ones.
- R8: A one-entry input holder keeps `smp_ready` high exactly when it is empty. While the holder is full, `smp_valid` and `smp_data` have no effect. The held sample is consumed at the next subframe start.
- R9: If the holder is empty at a subframe start, that subframe carries all-zero audio and a validity bit of 1.
- R10: During and just after reset the line is 0 and `smp_ready` is 1. The first subframe sent is position 0.
- R11: Every half-cell lasts HALF_DIV clocks, and the line changes only on half-cell boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Input holder empty |
| smp_data | input | AUDIO_W | Audio sample |
| inval_a | input | 1 | Validity bit for A subframes |
| inval_b | input | 1 | Validity bit for B subframes |
| meta_we | input | 1 | Bank write enable |
| meta_bank | input | 1 | 0 = channel status, 1 = user data |
| meta_addr | input | $clog2(BLOCK_LEN) | Subframe position to write |
| meta_bit | input | 1 | Bit value to write |
| line_o | output | 1 | Biphase-mark serial line |

## Verification
The hardest situations to reach are those tied to exact subframe positions: an underrun at a chosen position, the block wrap back to position 0, and a write that must be ignored while the holder is full. None of these can be timed from the ports without knowing where the stream currently stands. The bench therefore decodes the line itself: it locks onto the first rising half-cell, splits the stream into 64-half-cell subframes, and publishes the number of each subframe as it starts. A feeder process listens for that number. It refills the holder for the following subframe, skips the refill for positions 5, 6, 200 and 383 to cause underruns, and pushes rejected data while the holder is full. Partway through the run it also swaps the two validity inputs. The run covers one full block and the wrap into the next, and it checks every field against values computed arithmetically from the subframe number.

// File: rtl/bmc_audio_pkg.sv
package bmc_audio_pkg;
  localparam int SLOTS     = 32;
  localparam int HALVES    = 2 * SLOTS;
  localparam int PRE_SLOTS = 4;
  localparam int V_SLOT    = 28;
  localparam int U_SLOT    = 29;
  localparam int C_SLOT    = 30;
  localparam int P_SLOT    = 31;

  typedef enum logic [1:0] {
    SYNC_BLOCK  = 2'd0,
    SYNC_A      = 2'd1,
    SYNC_B      = 2'd2
  } sync_kind_e;

  // Half-cell patterns relative to a preceding line level of 0, MSB sent first.
  function automatic logic [7:0] sync_pattern(sync_kind_e kind);
    case (kind)
      SYNC_BLOCK: return 8'b1110_1000;
      SYNC_A:     return 8'b1110_0010;
      default:    return 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/bmc_half_tick.sv
module bmc_half_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bmc_bit_bank.sv
module bmc_bit_bank #(
  parameter int DEPTH = 384,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  logic mem [DEPTH];

  // Single write port, registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wbit;
    rbit <= mem[raddr];
  end
endmodule

// File: rtl/bmc_line_coder.sv
module bmc_line_coder
  import bmc_audio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        load,
  input  logic [31:0] load_word,
  input  logic [7:0]  load_sync,
  output logic        at_start,
  output logic        line_o
);
  logic [31:0] word_q;
  logic [7:0]  sync_q;
  logic        base_q;
  logic [5:0]  pos;
  logic        running;
  logic [4:0]  slot;
  logic        half;

  assign slot     = pos[5:1];
  assign half     = pos[0];
  assign at_start = !running || (pos == 6'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      sync_q  <= '0;
      base_q  <= 1'b0;
      pos     <= '0;
      running <= 1'b0;
      line_o  <= 1'b0;
    end else if (load) begin
      word_q  <= load_word;
      sync_q  <= load_sync;
      base_q  <= line_o;
      running <= 1'b1;
      pos     <= 6'd1;
      line_o  <= line_o ^ load_sync[7];
    end else if (tick && running && (pos != 6'd0)) begin
      pos <= pos + 6'd1;
      if (int'(slot) < PRE_SLOTS) line_o <= base_q ^ sync_q[~pos[2:0]];
      else if (!half)             line_o <= ~line_o;
      else if (word_q[slot])      line_o <= ~line_o;
    end
  end

  a_r11_quiet_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(line_o));
  a_r3_slot_edge_toggle: assert property (@(posedge clk) disable iff (rst)
    (tick && running && !load && pos >= 6'd8 && !pos[0]) |=> (line_o != $past(line_o)));
  a_r2_sync_returns_level: assert property (@(posedge clk) disable iff (rst)
    (running && pos == 6'd8) |-> (line_o == base_q));
  a_r7_even_parity: assert property (@(posedge clk) disable iff (rst)
    load |-> (^load_word[P_SLOT:PRE_SLOTS] == 1'b0));
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
  import bmc_audio_pkg::*;
#(
  parameter int AUDIO_W   = 20,
  parameter int BLOCK_LEN = 384,
  parameter int HALF_DIV  = 4,
  localparam int AW       = $clog2(BLOCK_LEN),
  localparam int AUDIO_LO = V_SLOT - AUDIO_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [AUDIO_W-1:0] smp_data,
  input  logic               inval_a,
  input  logic               inval_b,
  input  logic               meta_we,
  input  logic               meta_bank,
  input  logic [AW-1:0]      meta_addr,
  input  logic               meta_bit,
  output logic               line_o
);
  localparam logic [AW-1:0] POS_LAST = AW'(BLOCK_LEN - 1);

  logic               tick;
  logic               primed;
  logic               at_start;
  logic               load;
  logic [AW-1:0]      sf_pos;
  logic               hold_full;
  logic [AUDIO_W-1:0] hold_data;
  logic [1:0]         bank_rd;
  logic [31:0]        next_word;
  sync_kind_e         next_kind;
  logic [7:0]         next_sync;

  bmc_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  // Bank 0: channel status, bank 1: user data.
  for (genvar g = 0; g < 2; g++) begin : g_bank
    bmc_bit_bank #(.DEPTH(BLOCK_LEN)) u_bank (
      .clk   (clk),
      .we    (meta_we && (meta_bank == 1'(g))),
      .waddr (meta_addr),
      .wbit  (meta_bit),
      .raddr (sf_pos),
      .rbit  (bank_rd[g])
    );
  end

  // First tick after reset only primes, so bank reads for position 0 are settled.
  assign load      = tick && primed && at_start;
  assign smp_ready = !hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      sf_pos <= '0;
    end else begin
      if (tick) primed <= 1'b1;
      if (load) sf_pos <= (sf_pos == POS_LAST) ? '0 : sf_pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (!hold_full && smp_valid) begin
      hold_full <= 1'b1;
      hold_data <= smp_data;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_comb begin
    next_word = '0;
    if (hold_full) next_word[AUDIO_LO +: AUDIO_W] = hold_data;
    next_word[V_SLOT] = hold_full ? (sf_pos[0] ? inval_b : inval_a) : 1'b1;
    next_word[U_SLOT] = bank_rd[1];
    next_word[C_SLOT] = bank_rd[0];
    next_word[P_SLOT] = ^next_word[P_SLOT-1:PRE_SLOTS];
    if (sf_pos == '0)    next_kind = SYNC_BLOCK;
    else if (!sf_pos[0]) next_kind = SYNC_A;
    else                 next_kind = SYNC_B;
    next_sync = sync_pattern(next_kind);
  end

  bmc_line_coder u_coder (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .load      (load),
    .load_word (next_word),
    .load_sync (next_sync),
    .at_start  (at_start),
    .line_o    (line_o)
  );

  always_comb begin
    a_r1_pos_in_range: assert (rst || int'(sf_pos) < BLOCK_LEN);
  end

  a_r8_full_blocks_input: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_ready && !load) |=> !smp_ready);
  a_r8_full_holds_data: assert property (@(posedge clk) disable iff (rst)
    (!smp_ready && !load) |=> $stable(hold_data));
  a_r9_underrun_marks_invalid: assert property (@(posedge clk) disable iff (rst)
    (load && smp_ready) |-> (next_word[V_SLOT] && next_word[AUDIO_LO +: AUDIO_W] == '0));
  a_r2_block_start_sync: assert property (@(posedge clk) disable iff (rst)
    (load && sf_pos == '0) |-> (next_sync == 8'b1110_1000));
endmodule

// File: tb/bmc_audio_tx_tb.sv
module bmc_audio_tx_tb_top;
  localparam int AW_T   = 20;
  localparam int BLK    = 384;
  localparam int HD     = 2;
  localparam int NSF    = 390;
  localparam int ABITS  = $clog2(BLK);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            smp_valid = 1'b0;
  logic            smp_ready;
  logic [AW_T-1:0] smp_data = '0;
  logic            inval_a = 1'b0;
  logic            inval_b = 1'b1;
  logic            meta_we = 1'b0;
  logic            meta_bank = 1'b0;
  logic [ABITS-1:0] meta_addr = '0;
  logic            meta_bit = 1'b0;
  logic            line_o;

  int n_cmp = 0;
  int n_bad = 0;
  int sf_now = -1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bmc_audio_tx #(.AUDIO_W(AW_T), .BLOCK_LEN(BLK), .HALF_DIV(HD)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_data  (smp_data),
    .inval_a   (inval_a),
    .inval_b   (inval_b),
    .meta_we   (meta_we),
    .meta_bank (meta_bank),
    .meta_addr (meta_addr),
    .meta_bit  (meta_bit),
    .line_o    (line_o)
  );

  function automatic logic [AW_T-1:0] smp_val(int k);
    return AW_T'((k * 40503 + 777) ^ (k << 9));
  endfunction
  function automatic bit cs_bit(int i);
    return ((i % 3) == 0) ^ (i >= 190);
  endfunction
  function automatic bit us_bit(int i);
    return ((i % 5) == 1) || (i == 383);
  endfunction
  function automatic bit starved(int k);
    return (k == 5) || (k == 6) || (k == 200) || (k == 383);
  endfunction

  task automatic chk(string req, longint got, longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic push(int k);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = smp_val(k);
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R8 ready low once holder full", smp_ready, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : feeder
    forever begin
      @(sf_now);
      begin
        int k;
        k = sf_now;
        if (!starved(k + 1)) push(k + 1);
        if (k == 50) begin
          // R8: offers while full must be ignored; subframe 51 audio proves it.
          @(negedge clk);
          smp_valid = 1'b1;
          smp_data  = '1;
          repeat (3) begin
            @(negedge clk);
            chk("R8 ready stays low while full", smp_ready, 0);
          end
          smp_valid = 1'b0;
        end
        if (k == 100) begin
          inval_a = 1'b1;
          inval_b = 1'b0;
        end
      end
    end
  end

  initial begin : main
    logic h [64];
    logic [31:0] bits;
    logic prev;
    for (int i = 0; i < BLK; i++) begin
      @(negedge clk);
      meta_we = 1'b1; meta_bank = 1'b0; meta_addr = ABITS'(i); meta_bit = cs_bit(i);
      @(negedge clk);
      meta_bank = 1'b1; meta_bit = us_bit(i);
    end
    @(negedge clk);
    meta_we = 1'b0;
    chk("R10 line low in reset", line_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 line low after reset", line_o, 0);
    chk("R10 ready high after reset", smp_ready, 1);
    push(0);
    while (line_o !== 1'b1) @(negedge clk);
    prev = 1'b0;
    for (int k = 0; k < NSF; k++) begin
      int bp_err;
      int hc_err;
      int idx;
      logic [7:0] got_sync;
      logic [7:0] exp_sync;
      bit exp_v;
      hc_err = 0;
      for (int j = 0; j < 64; j++) begin
        logic a;
        if (!(k == 0 && j == 0)) @(negedge clk);
        a = line_o;
        repeat (HD - 1) @(negedge clk);
        if (line_o !== a) hc_err++;
        h[j] = a;
        if (j == 0) sf_now = k;
      end
      idx = k % BLK;
      chk("R11 half-cell stable for HALF_DIV clocks", hc_err, 0);
      for (int j = 0; j < 8; j++) got_sync[7-j] = h[j] ^ prev;
      if (idx == 0)          exp_sync = 8'b1110_1000;
      else if (idx % 2 == 0) exp_sync = 8'b1110_0010;
      else                   exp_sync = 8'b1110_0100;
      chk((k == 0) ? "R10 first subframe is block start" : "R2 preamble", got_sync, exp_sync);
      bp_err = 0;
      bits = '0;
      for (int b = 4; b < 32; b++) begin
        if (h[2*b] == h[2*b-1]) bp_err++;
        bits[b] = h[2*b] ^ h[2*b+1];
      end
      chk("R3 slot-edge toggles", bp_err, 0);
      chk("R1 R4 aux slots zero", bits[7:4], 0);
      chk(starved(k) ? "R9 underrun audio zero" : "R4 audio LSB first",
          bits[27:8], starved(k) ? 0 : smp_val(k));
      if (starved(k))     exp_v = 1'b1;
      else if (k <= 100)  exp_v = (idx % 2 == 1);
      else                exp_v = (idx % 2 == 0);
      chk(starved(k) ? "R9 underrun validity" : "R6 validity per side", bits[28], exp_v);
      chk("R5 user bit", bits[29], us_bit(idx));
      chk("R5 status bit", bits[30], cs_bit(idx));
      chk("R7 parity", ^bits[31:4], 0);
      prev = h[63];
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule